// File: doc/BRIEF.md
# Mesh Router Turn-Policy Route Unit

This unit computes the output port for a head flit in a two-dimensional mesh router. From the router's own coordinates, the packet's destination coordinates and the port the flit came in on, it works out the set of output directions that move the packet closer to its destination. It then removes every direction that the selected turn policy does not permit, and picks one port from what is left. A run-time mode input selects the policy:

- dimension-order routing (X then Y)
- west-first
- north-last
- negative-first
- odd-even, whose rules depend on whether the router's column is even or odd

The unit also checks a route that was computed elsewhere. A probe port input names an intended output direction. A flag reports whether leaving on that port would make a turn that the current policy forbids at this router.

Each request is presented with a valid strobe. All results are registered and appear exactly one cycle later, together, so the unit fits as one pipeline stage of a router's head-flit path.

Top module: `route_turn_unit`

## Requirements
- R1: After synchronous reset, and in any cycle whose previous cycle carried no valid request, `out_valid`, `out_mask`, `out_sel`, `out_dead` and `out_bad` are all zero. A request with `in_valid` high produces its results with `out_valid` high on the following cycle.
- R2: Port codes are local=0, east=1, west=2, north=3, south=4. East means increasing x and north means increasing y. Bit k of `out_mask` stands for port code k. Only minimal directions are offered: east only if dst_x>cur_x, west only if dst_x<cur_x, north only if dst_y>cur_y, south only if dst_y<cur_y.
- R3: When the current coordinates equal the destination, `out_mask` is 5'b00001 and `out_sel` is local, in every mode.
- R4: Mode 0 (dimension order): Y directions are offered only when no X direction is needed. A packet travelling north or south may not turn east or west. Mode codes 5 to 7 behave as mode 0.
- R5: Mode 1 (west-first): when west is needed, it is the only direction offered. Turns from north or south travel into west are forbidden.
- R6: Mode 2 (north-last): north is offered only when no X direction is needed. A packet travelling north may not turn east or west.
- R7: Mode 3 (negative-first): when west or south is needed, only west and south are offered. The turns east-to-south and north-to-west are forbidden.
- R8: Mode 4 (odd-even): the column parity is bit 0 of cur_x. In even columns, a packet travelling east may not turn north or south. In odd columns, a packet travelling north or south may not turn west.
- R9: The travel direction of a flit is opposite to the port it arrived on (arriving on the west port means travelling east). A flit arriving on the local port, or on an unused code 5 to 7, is under no turn restriction. Continuing straight is always legal, and reversing is always forbidden.
- R10: `out_sel` takes an X direction from the mask when one is present, and otherwise a Y direction. If no direction survives away from the destination, `out_dead` is 1 and `out_sel` is local.
- R11: `out_bad` is 1 when `probe_port` names a forbidden turn under the current mode and column parity, or names a code 5 to 7. A probe of local never sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| mode | input | 3 | Turn policy code |
| cur_x | input | XW | Router column |
| cur_y | input | YW | Router row |
| dst_x | input | XW | Destination column |
| dst_y | input | YW | Destination row |
| in_port | input | 3 | Port the flit arrived on |
| probe_port | input | 3 | Output port to check for turn legality |
| out_valid | output | 1 | Results valid |
| out_mask | output | 5 | Permitted output ports, one bit per port code |
| out_sel | output | 3 | Chosen output port |
| out_dead | output | 1 | No permitted direction although not at the destination |
| out_bad | output | 1 | Probe port forms a forbidden turn |

## Verification
The hardest situations to reach are those where the minimal direction set and the arrival direction combine so that a policy leaves nothing. One example is a flit travelling east in an even column under odd-even whose destination lies straight north. Another is a west-first flit travelling north that still needs to go west. Random coordinates rarely produce these. The stimulus therefore places the router on chosen columns of each parity and sets the arrival port to fix the travel direction. It then sweeps every mode, arrival port and probe port over a grid of destinations placed around the router, so that every turn pair is visited at both column parities.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int NPORT = 5;

    typedef enum logic [2:0] {
        P_LOCAL = 3'd0,
        P_EAST  = 3'd1,
        P_WEST  = 3'd2,
        P_NORTH = 3'd3,
        P_SOUTH = 3'd4
    } port_e;

    typedef enum logic [2:0] {
        M_XY = 3'd0,
        M_WF = 3'd1,
        M_NL = 3'd2,
        M_NF = 3'd3,
        M_OE = 3'd4
    } mode_e;

    typedef struct packed {
        logic [NPORT-1:0] mask;
        port_e            sel;
        logic             dead;
        logic             bad;
    } route_res_t;

    // Opposite direction; also maps an arrival port to the travel direction.
    function automatic port_e flip(input logic [2:0] p);
        case (p)
            3'd1:    return P_WEST;
            3'd2:    return P_EAST;
            3'd3:    return P_SOUTH;
            3'd4:    return P_NORTH;
            default: return P_LOCAL;
        endcase
    endfunction

    function automatic logic is_x(input port_e p);
        return (p == P_EAST) || (p == P_WEST);
    endfunction

    function automatic logic is_y(input port_e p);
        return (p == P_NORTH) || (p == P_SOUTH);
    endfunction

    // Forbidden-turn test for travel direction tin leaving as tout.
    function automatic logic turn_bad(input logic [2:0] mode, input logic odd,
                                      input port_e tin, input port_e tout);
        logic r;
        if (tin == P_LOCAL || tout == P_LOCAL) return 1'b0;
        if (tin == tout) return 1'b0;
        if (flip(tin) == tout) return 1'b1;
        case (mode)
            M_WF: r = (tout == P_WEST) && is_y(tin);
            M_NL: r = (tin == P_NORTH) && is_x(tout);
            M_NF: r = ((tin == P_EAST) && (tout == P_SOUTH)) ||
                      ((tin == P_NORTH) && (tout == P_WEST));
            M_OE: r = odd ? ((tout == P_WEST) && is_y(tin))
                          : ((tin == P_EAST) && is_y(tout));
            default: r = is_y(tin) && is_x(tout);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rtc_span.sv
module rtc_span
    import rtc_pkg::*;
#(
    parameter int XW = 4,
    parameter int YW = 4
) (
    input  logic [XW-1:0]    cur_x,
    input  logic [YW-1:0]    cur_y,
    input  logic [XW-1:0]    dst_x,
    input  logic [YW-1:0]    dst_y,
    output logic [NPORT-1:0] need,
    output logic             home
);
    always_comb begin
        need          = '0;
        need[P_EAST]  = dst_x > cur_x;
        need[P_WEST]  = dst_x < cur_x;
        need[P_NORTH] = dst_y > cur_y;
        need[P_SOUTH] = dst_y < cur_y;
        home          = (dst_x == cur_x) && (dst_y == cur_y);
    end
endmodule

// File: rtl/rtc_policy.sv
module rtc_policy
    import rtc_pkg::*;
(
    input  logic [2:0]       mode,
    input  logic             odd,
    input  port_e            tin,
    input  logic [NPORT-1:0] need,
    output logic [NPORT-1:0] allow
);
    logic [NPORT-1:0] pre;
    logic             want_x;
    logic             want_neg;

    always_comb begin
        want_x   = need[P_EAST] | need[P_WEST];
        want_neg = need[P_WEST] | need[P_SOUTH];
        pre      = need;
        case (mode)
            M_WF: if (need[P_WEST]) begin
                pre = '0;
                pre[P_WEST] = 1'b1;
            end
            M_NL: if (want_x) pre[P_NORTH] = 1'b0;
            M_NF: if (want_neg) begin
                pre[P_EAST]  = 1'b0;
                pre[P_NORTH] = 1'b0;
            end
            M_OE: ;
            default: if (want_x) begin
                pre[P_NORTH] = 1'b0;
                pre[P_SOUTH] = 1'b0;
            end
        endcase
    end

    assign allow[0] = 1'b0;
    for (genvar d = 1; d < NPORT; d++) begin : g_dir
        assign allow[d] = pre[d] & ~turn_bad(mode, odd, tin, port_e'(3'(d)));
    end
endmodule

// File: rtl/rtc_pick.sv
module rtc_pick
    import rtc_pkg::*;
(
    input  logic [NPORT-1:0] allow,
    output port_e            sel,
    output logic             dead
);
    always_comb begin
        dead = 1'b0;
        if      (allow[P_EAST])  sel = P_EAST;
        else if (allow[P_WEST])  sel = P_WEST;
        else if (allow[P_NORTH]) sel = P_NORTH;
        else if (allow[P_SOUTH]) sel = P_SOUTH;
        else begin
            sel  = P_LOCAL;
            dead = 1'b1;
        end
    end
endmodule

// File: rtl/route_turn_unit.sv
module route_turn_unit
    import rtc_pkg::*;
#(
    parameter int XW = 4,
    parameter int YW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [2:0]    mode,
    input  logic [XW-1:0] cur_x,
    input  logic [YW-1:0] cur_y,
    input  logic [XW-1:0] dst_x,
    input  logic [YW-1:0] dst_y,
    input  logic [2:0]    in_port,
    input  logic [2:0]    probe_port,
    output logic          out_valid,
    output logic [4:0]    out_mask,
    output logic [2:0]    out_sel,
    output logic          out_dead,
    output logic          out_bad
);
    logic [NPORT-1:0] need;
    logic [NPORT-1:0] allow;
    logic             home;
    logic             odd;
    port_e            tin;
    port_e            pick_sel;
    logic             pick_dead;
    route_res_t       nxt;
    route_res_t       res_q;
    logic             vld_q;

    assign odd = cur_x[0];
    assign tin = flip(in_port);

    rtc_span #(.XW(XW), .YW(YW)) u_span (
        .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y),
        .need(need), .home(home)
    );

    rtc_policy u_policy (
        .mode(mode), .odd(odd), .tin(tin), .need(need), .allow(allow)
    );

    rtc_pick u_pick (
        .allow(allow), .sel(pick_sel), .dead(pick_dead)
    );

    always_comb begin
        if (home) begin
            nxt.mask = 5'b00001;
            nxt.sel  = P_LOCAL;
            nxt.dead = 1'b0;
        end else begin
            nxt.mask = allow;
            nxt.sel  = pick_sel;
            nxt.dead = pick_dead;
        end
        if (probe_port > 3'd4) nxt.bad = 1'b1;
        else nxt.bad = turn_bad(mode, odd, tin, port_e'(probe_port));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            vld_q <= in_valid;
            res_q <= in_valid ? nxt : '0;
        end
    end

    assign out_valid = vld_q;
    assign out_mask  = res_q.mask;
    assign out_sel   = res_q.sel;
    assign out_dead  = res_q.dead;
    assign out_bad   = res_q.bad;
endmodule

// File: rtl/rtc_chk.sv
module rtc_chk #(
    parameter int XW = 4,
    parameter int YW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic [2:0]    mode,
    input logic [XW-1:0] cur_x,
    input logic [YW-1:0] cur_y,
    input logic [XW-1:0] dst_x,
    input logic [YW-1:0] dst_y,
    input logic [2:0]    in_port,
    input logic [2:0]    probe_port,
    input logic          out_valid,
    input logic [4:0]    out_mask,
    input logic [2:0]    out_sel,
    input logic          out_dead,
    input logic          out_bad
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_mask == 5'b0 && out_sel == 3'd0 && !out_dead && !out_bad));

    // R1
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R2
    no_opposite_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !(out_mask[1] && out_mask[2]) && !(out_mask[3] && out_mask[4]));

    // R3
    home_local_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && $past(cur_x == dst_x && cur_y == dst_y) |-> (out_sel == 3'd0 && out_mask == 5'b00001));

    // R4
    xy_first_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && $past(mode) == 3'd0 && (out_mask[1] || out_mask[2]) |-> !out_mask[3] && !out_mask[4]);

    // R10
    sel_in_mask_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_dead |-> out_mask[out_sel]);

    // R11
    local_probe_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && $past(probe_port) == 3'd0 |-> !out_bad);
endmodule

bind route_turn_unit rtc_chk #(.XW(XW), .YW(YW)) u_chk (.*);

// File: tb/sim_route_turn_unit.sv
`timescale 1ns/1ps
module sim_route_turn_unit;
    localparam int XW = 4;
    localparam int YW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [2:0]    mode = '0;
    logic [XW-1:0] cur_x = '0;
    logic [YW-1:0] cur_y = '0;
    logic [XW-1:0] dst_x = '0;
    logic [YW-1:0] dst_y = '0;
    logic [2:0]    in_port = '0;
    logic [2:0]    probe_port = '0;
    logic          out_valid;
    logic [4:0]    out_mask;
    logic [2:0]    out_sel;
    logic          out_dead;
    logic          out_bad;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [9:0] exp_q[$];
    string      tag_q[$];

    route_turn_unit #(.XW(XW), .YW(YW)) u0 (.*);

    always #4 clk = ~clk;

    // travel direction codes: 1 E, 2 W, 3 N, 4 S, 0 none
    function automatic int travel(input int p);
        case (p)
            1: return 2;
            2: return 1;
            3: return 4;
            4: return 3;
            default: return 0;
        endcase
    endfunction

    function automatic bit forbid(input int m, input bit odd, input int a, input int b);
        bit ay = (a == 3 || a == 4);
        bit bx = (b == 1 || b == 2);
        bit by = (b == 3 || b == 4);
        if (a == 0 || b == 0 || a == b) return 0;
        if (travel(a) == b) return 1;
        if (m == 1) return ay && b == 2;
        if (m == 2) return a == 3 && bx;
        if (m == 3) return (a == 1 && b == 4) || (a == 3 && b == 2);
        if (m == 4) return odd ? (ay && b == 2) : (a == 1 && by);
        return ay && bx;
    endfunction

    function automatic logic [9:0] model(input int m, input int cx, input int cy,
                                         input int dx, input int dy, input int ip, input int pp);
        bit [4:0] c;
        bit [4:0] k;
        int s;
        bit dead;
        bit bad;
        bit odd = cx[0];
        int t = travel(ip);
        c = '0;
        c[1] = dx > cx; c[2] = dx < cx; c[3] = dy > cy; c[4] = dy < cy;
        k = c;
        if (m == 1) begin
            if (c[2]) k = 5'b00100;
        end else if (m == 2) begin
            if (c[1] || c[2]) k[3] = 0;
        end else if (m == 3) begin
            if (c[2] || c[4]) begin k[1] = 0; k[3] = 0; end
        end else if (m != 4) begin
            if (c[1] || c[2]) begin k[3] = 0; k[4] = 0; end
        end
        for (int d = 1; d < 5; d++) if (forbid(m, odd, t, d)) k[d] = 0;
        dead = 0;
        if (k[1]) s = 1; else if (k[2]) s = 2; else if (k[3]) s = 3;
        else if (k[4]) s = 4; else begin s = 0; dead = 1; end
        if (cx == dx && cy == dy) begin k = 5'b00001; s = 0; dead = 0; end
        bad = (pp > 4) ? 1'b1 : forbid(m, odd, t, pp);
        return {k, 3'(s), dead, bad};
    endfunction

    task automatic drive(input string tag, input int m, input int cx, input int cy,
                         input int dx, input int dy, input int ip, input int pp);
        @(negedge clk);
        in_valid   = 1'b1;
        mode       = 3'(m);
        cur_x      = XW'(cx); cur_y = YW'(cy);
        dst_x      = XW'(dx); dst_y = YW'(dy);
        in_port    = 3'(ip);
        probe_port = 3'(pp);
        exp_q.push_back(model(m, cx, cy, dx, dy, ip, pp));
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // monitor: scoreboard compare
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            logic [9:0] e;
            string t;
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R1: unexpected out_valid, act=%b exp=none", out_valid);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if ({out_mask, out_sel, out_dead, out_bad} !== e) begin
                    errors++;
                    $display("FAIL %s: act mask=%b sel=%0d dead=%b bad=%b exp mask=%b sel=%0d dead=%b bad=%b",
                             t, out_mask, out_sel, out_dead, out_bad, e[9:5], e[4:2], e[1], e[0]);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: act=hung exp=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        checks++;
        if (out_valid !== 1'b0 || out_mask !== 5'b0 || out_sel !== 3'd0 || out_dead !== 1'b0 || out_bad !== 1'b0) begin
            errors++;
            $display("FAIL R1: act valid=%b mask=%b exp valid=0 mask=00000", out_valid, out_mask);
        end
        // R3 at destination in each mode
        for (int m = 0; m < 5; m++) drive("R3", m, 5, 5, 5, 5, 1, 0);
        // R2 minimal set, odd-even with no restriction from local
        drive("R2", 4, 6, 6, 9, 2, 0, 0);
        drive("R2", 4, 6, 6, 1, 6, 0, 0);
        // R4 dimension order and default codes
        drive("R4", 0, 2, 2, 5, 7, 0, 0);
        drive("R4", 6, 2, 2, 5, 7, 0, 0);
        drive("R4", 0, 4, 4, 4, 9, 4, 1);
        // R5 west-first
        drive("R5", 1, 6, 2, 1, 7, 0, 0);
        drive("R5", 1, 6, 2, 1, 7, 4, 2);
        // R6 north-last
        drive("R6", 2, 2, 2, 5, 7, 0, 0);
        drive("R6", 2, 5, 2, 5, 7, 4, 1);
        // R7 negative-first
        drive("R7", 3, 5, 5, 2, 8, 0, 0);
        drive("R7", 3, 2, 6, 2, 1, 2, 4);
        // R8 odd-even parity
        drive("R8", 4, 4, 3, 4, 9, 2, 3);
        drive("R8", 4, 5, 3, 5, 9, 2, 3);
        drive("R8", 4, 5, 3, 2, 9, 4, 2);
        // R10 X preferred
        drive("R10", 4, 4, 3, 1, 9, 4, 0);
        drive("R10", 1, 2, 2, 5, 7, 0, 0);
        // R9 straight, reversal, unused arrival codes
        drive("R9", 0, 4, 4, 4, 9, 4, 3);
        drive("R9", 0, 4, 4, 4, 9, 4, 4);
        drive("R9", 0, 4, 4, 9, 9, 6, 3);
        // R11 probe codes
        drive("R11", 2, 4, 4, 4, 9, 4, 0);
        drive("R11", 2, 4, 4, 4, 9, 4, 6);
        drive("R11", 4, 3, 4, 3, 9, 4, 2);
        idle();
        idle();
        // R1 quiet after idle
        checks++;
        if (out_valid !== 1'b0 || out_mask !== 5'b0) begin
            errors++;
            $display("FAIL R1: idle act valid=%b mask=%b exp valid=0 mask=00000", out_valid, out_mask);
        end
        // sweep over modes, arrival and probe ports, parities and destinations
        for (int m = 0; m < 5; m++)
            for (int cx = 6; cx < 8; cx++)
                for (int ip = 0; ip < 5; ip++)
                    for (int pp = 0; pp < 5; pp++)
                        for (int dd = 0; dd < 9; dd++)
                            drive("sweep", m, cx, 7, cx + (dd % 3) * 3 - 3, 7 + (dd / 3) * 3 - 3, ip, pp);
        idle();
        idle();
        idle();
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R1: pending act=%0d exp=0", exp_q.size());
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule